// File: doc/BRIEF.md
# Reset-Time Boot Load Sequencer

After reset is released, this block decides how on-chip program memory gets its first contents. It reads three mode inputs once, in the first cycle after reset, and picks one of three paths. On the byte-memory path it reads 96 bytes in a row from an 8-bit external byte memory. The byte address starts at zero and every other DMA setting stays at its fixed default: transfer direction is read, transfer type is 24-bit program words, page zero, internal address zero. It packs each group of three bytes into one 24-bit word and writes 32 words to program memory at addresses 0 to 31, while the core-run enable stays low. On the host path it passes host writes through to program memory, as many as the host wants, and releases the core once the host writes program address 0. On any other mode setting it releases the core at once.

When the narrow-address input is high, only bit 0 of the byte address is driven. The upper byte-address bits then come from external logic, which counts the reads.

The state machine has four states. ST_PICK is the reset state and decodes the mode. ST_BYTE runs the byte-memory load. ST_HOST waits for host writes. ST_RUN is terminal and drives the run enable. The transitions are:
- PICK to BYTE on mode 000.
- PICK to HOST on mode 101.
- PICK to RUN on any other mode.
- BYTE to RUN after the cycle in which the 32nd word is written.
- HOST to RUN after the cycle in which the write to address 0 is presented.

Top module: `boot_seq`

## Requirements
- R1: The mode is read as {mode_c, mode_b, mode_a} in the first cycle after reset release. 000 selects the byte-memory load, 101 selects host load, and any other value raises run_en right after the first clock edge, with no memory traffic.
- R2: run_en is 0 during reset and for the whole load. Once it is 1 it stays 1 until the next reset.
- R3: The byte-memory load issues exactly 96 reads, one per cycle, at byte addresses 0, 1, 2 … 95, with all upper address bits 0. Read data is taken from bm_data in the cycle after the read request.
- R4: Each program word holds three consecutive bytes: the first byte read in bits 23:16, the second in bits 15:8 and the third in bits 7:0.
- R5: The byte-memory load writes exactly 32 words, to program addresses 0 to 31 in increasing order, and makes no other program-memory writes.
- R6: run_en becomes 1 in the cycle right after the cycle in which pm_we shows the final write. This applies to word 31 on the byte path and to the address-0 write on the host path.
- R7: On the host path, each host write (host_we high at a clock edge) appears on the program-memory port one cycle later with the same address and data. Any number of writes, to any nonzero addresses, may come first.
- R8: These host writes have no effect and never reach pm_we: host writes during the byte-memory load, host writes in the cycle after the address-0 write, and host writes after release.
- R9: With narrow_addr = 1, bm_addr bits above bit 0 are 0, and bit 0 equals bit 0 of the true byte address.
- R10: Changes on the mode inputs after the first cycle after reset do not change the chosen path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_a | input | 1 | Boot mode bit 0 |
| mode_b | input | 1 | Boot mode bit 1 |
| mode_c | input | 1 | Boot mode bit 2 |
| narrow_addr | input | 1 | Drive only byte-address bit 0 |
| bm_rd | output | 1 | Byte-memory read request |
| bm_addr | output | BA_W (22) | Byte-memory address |
| bm_data | input | 8 | Byte read data, valid the cycle after the request |
| host_we | input | 1 | Host program-memory write strobe |
| host_addr | input | PA_W (14) | Host write address |
| host_data | input | 24 | Host write data |
| pm_we | output | 1 | Program-memory write enable |
| pm_addr | output | PA_W (14) | Program-memory write address |
| pm_wdata | output | 24 | Program-memory write data |
| run_en | output | 1 | Core run enable |

## Verification
The hardest case to reach from the ports is the host path's end: a second host write that lands in the same cycle the address-0 write is still on the program-memory port. It has to be dropped, even though the machine has not yet left the host state. The bench drives a fresh host write right after the address-0 write and checks that pm_we is low while run_en rises. On the byte path, random host writes and mode-pin toggles are applied in the middle of the load. The 32 words are then compared against words the bench builds from its own byte function, in both full and narrow addressing.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [1:0] {
        ST_PICK,
        ST_BYTE,
        ST_HOST,
        ST_RUN
    } boot_state_t;

    typedef enum logic [1:0] {
        PATH_BYTE,
        PATH_HOST,
        PATH_NONE
    } boot_path_t;

endpackage

// File: rtl/boot_mode_dec.sv
module boot_mode_dec
    import boot_pkg::*;
(
    input  logic       mode_a,
    input  logic       mode_b,
    input  logic       mode_c,
    output boot_path_t path
);
    logic [2:0] code;
    assign code = {mode_c, mode_b, mode_a};

    always_comb begin
        unique case (code)
            3'b000:  path = PATH_BYTE;
            3'b101:  path = PATH_HOST;
            default: path = PATH_NONE;
        endcase
    end
endmodule

// File: rtl/boot_byte_pack.sv
module boot_byte_pack #(
    parameter int BYTE_W     = 8,
    parameter int WORD_W     = 24,
    parameter int BA_W       = 22,
    parameter int PA_W       = 14,
    parameter int BOOT_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    output logic              rd_req,
    output logic [BA_W-1:0]   rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wd_vld,
    output logic              wd_last,
    output logic [PA_W-1:0]   wd_addr,
    output logic [WORD_W-1:0] wd_data
);
    localparam int BPW   = WORD_W / BYTE_W;
    localparam int TOTAL = BOOT_WORDS * BPW;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam int WI_W  = $clog2(BOOT_WORDS + 1);
    localparam int PH_W  = $clog2(BPW);
    localparam int ASM_W = WORD_W - BYTE_W;

    logic [CNT_W-1:0]  rd_cnt;
    logic              rd_v;
    logic [PH_W-1:0]   phase;
    logic [WI_W-1:0]   widx;
    logic [ASM_W-1:0]  asm_q;
    logic [WORD_W-1:0] joined;

    assign rd_req  = active && (rd_cnt < CNT_W'(TOTAL));
    assign rd_addr = BA_W'(rd_cnt);
    assign joined  = {asm_q, rd_data};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt  <= '0;
            rd_v    <= 1'b0;
            phase   <= '0;
            widx    <= '0;
            asm_q   <= '0;
            wd_vld  <= 1'b0;
            wd_last <= 1'b0;
            wd_addr <= '0;
            wd_data <= '0;
        end else begin
            rd_v   <= rd_req;
            wd_vld <= 1'b0;
            if (rd_req) rd_cnt <= rd_cnt + 1'b1;
            if (rd_v) begin
                asm_q <= joined[ASM_W-1:0];
                if (phase == PH_W'(BPW - 1)) begin
                    phase   <= '0;
                    wd_vld  <= 1'b1;
                    wd_data <= joined;
                    wd_addr <= PA_W'(widx);
                    wd_last <= (widx == WI_W'(BOOT_WORDS - 1));
                    widx    <= widx + 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int WORD_W     = 24,
    parameter int BA_W       = 22,
    parameter int PA_W       = 14,
    parameter int BOOT_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_a,
    input  logic              mode_b,
    input  logic              mode_c,
    input  logic              narrow_addr,
    output logic              bm_rd,
    output logic [BA_W-1:0]   bm_addr,
    input  logic [BYTE_W-1:0] bm_data,
    input  logic              host_we,
    input  logic [PA_W-1:0]   host_addr,
    input  logic [WORD_W-1:0] host_data,
    output logic              pm_we,
    output logic [PA_W-1:0]   pm_addr,
    output logic [WORD_W-1:0] pm_wdata,
    output logic              run_en
);
    boot_state_t       state_q, state_d;
    boot_path_t        path;
    logic              eng_on;
    logic [BA_W-1:0]   full_addr;
    logic              wd_vld, wd_last;
    logic [PA_W-1:0]   wd_addr;
    logic [WORD_W-1:0] wd_data;
    logic              hv_q, hz_q;
    logic [PA_W-1:0]   ha_q;
    logic [WORD_W-1:0] hd_q;
    logic              host_open;

    boot_mode_dec u_dec (
        .mode_a (mode_a),
        .mode_b (mode_b),
        .mode_c (mode_c),
        .path   (path)
    );

    assign eng_on = (state_q == ST_BYTE);

    boot_byte_pack #(
        .BYTE_W(BYTE_W), .WORD_W(WORD_W), .BA_W(BA_W),
        .PA_W(PA_W), .BOOT_WORDS(BOOT_WORDS)
    ) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (eng_on),
        .rd_req  (bm_rd),
        .rd_addr (full_addr),
        .rd_data (bm_data),
        .wd_vld  (wd_vld),
        .wd_last (wd_last),
        .wd_addr (wd_addr),
        .wd_data (wd_data)
    );

    assign bm_addr = narrow_addr ? BA_W'(full_addr[0]) : full_addr;

    // host writes are taken only while waiting and not after the address-0 write
    assign host_open = (state_q == ST_HOST) && !(hv_q && hz_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv_q <= 1'b0;
            hz_q <= 1'b0;
            ha_q <= '0;
            hd_q <= '0;
        end else begin
            hv_q <= host_open && host_we;
            if (host_open && host_we) begin
                hz_q <= (host_addr == '0);
                ha_q <= host_addr;
                hd_q <= host_data;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PICK: begin
                unique case (path)
                    PATH_BYTE: state_d = ST_BYTE;
                    PATH_HOST: state_d = ST_HOST;
                    default:   state_d = ST_RUN;
                endcase
            end
            ST_BYTE: if (wd_vld && wd_last) state_d = ST_RUN;
            ST_HOST: if (hv_q && hz_q) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_PICK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PICK;
        else        state_q <= state_d;
    end

    always_comb begin
        pm_we    = 1'b0;
        pm_addr  = '0;
        pm_wdata = '0;
        run_en   = 1'b0;
        unique case (state_q)
            ST_BYTE: begin
                pm_we    = wd_vld;
                pm_addr  = wd_addr;
                pm_wdata = wd_data;
            end
            ST_HOST: begin
                pm_we    = hv_q;
                pm_addr  = ha_q;
                pm_wdata = hd_q;
            end
            ST_RUN:  run_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
    import boot_pkg::*;
#(
    parameter int BA_W       = 22,
    parameter int PA_W       = 14,
    parameter int BOOT_WORDS = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            pm_we,
    input logic [PA_W-1:0] pm_addr,
    input logic            bm_rd,
    input logic [BA_W-1:0] bm_addr,
    input logic            narrow_addr,
    input boot_state_t     st
);
    p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> run_en);

    p_no_write_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> !pm_we);

    p_reads_only_in_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bm_rd |-> (st == ST_BYTE && !run_en));

    p_narrow_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_rd && narrow_addr) |-> (bm_addr[BA_W-1:1] == '0));

    p_release_follows_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> ($past(pm_we) || $past(st) == ST_PICK));

    p_byte_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_we && st == ST_BYTE) |-> (pm_addr < PA_W'(BOOT_WORDS)));
endmodule

bind boot_seq boot_seq_chk #(.BA_W(BA_W), .PA_W(PA_W), .BOOT_WORDS(BOOT_WORDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .pm_we       (pm_we),
    .pm_addr     (pm_addr),
    .bm_rd       (bm_rd),
    .bm_addr     (bm_addr),
    .narrow_addr (narrow_addr),
    .st          (state_q)
);

// File: tb/sim_boot_seq.sv
`timescale 1ns/1ps
module sim_boot_seq;
    localparam int BA_W = 22;
    localparam int PA_W = 14;
    localparam int NW   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_a = 1'b0, mode_b = 1'b0, mode_c = 1'b0;
    logic              narrow_addr = 1'b0;
    logic              bm_rd;
    logic [BA_W-1:0]   bm_addr;
    logic [7:0]        bm_data = 8'h00;
    logic              host_we = 1'b0;
    logic [PA_W-1:0]   host_addr = '0;
    logic [23:0]       host_data = '0;
    logic              pm_we;
    logic [PA_W-1:0]   pm_addr;
    logic [23:0]       pm_wdata;
    logic              run_en;

    int total = 0;
    int bad = 0;
    int rcount = 0;
    int req_cnt = 0;
    bit req_q = 1'b0;
    logic [7:0] seed = 8'h00;
    int cycles = 0;

    always #10 clk = ~clk;

    boot_seq u0 (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b), .mode_c(mode_c),
        .narrow_addr(narrow_addr), .bm_rd(bm_rd), .bm_addr(bm_addr), .bm_data(bm_data),
        .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata), .run_en(run_en)
    );

    function automatic logic [7:0] byte_fn(logic [7:0] s, int i);
        logic [31:0] v;
        v = (i * 37 + 32'(s)) ^ (i >> 3);
        return v[7:0];
    endfunction

    function automatic logic [23:0] word_fn(logic [7:0] s, int w);
        return {byte_fn(s, 3 * w), byte_fn(s, 3 * w + 1), byte_fn(s, 3 * w + 2)};
    endfunction

    // external byte memory: request seen in a cycle, data presented at the next edge
    always @(negedge clk) begin
        req_q   <= bm_rd;
        req_cnt <= rcount;
    end
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (req_q) begin
            bm_data <= byte_fn(seed, req_cnt);
            rcount  <= rcount + 1;
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL R2 watchdog expired act=%0d exp=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m, input logic nar);
        @(negedge clk);
        rst_n = 1'b0;
        {mode_c, mode_b, mode_a} = m;
        narrow_addr = nar;
        host_we = 1'b0;
        repeat (3) @(negedge clk);
        rcount = 0;
        chk(!run_en && !pm_we && !bm_rd, "R2 reset outputs idle", {run_en, pm_we, bm_rd}, 0);
        rst_n = 1'b1;
    endtask

    task automatic skip_mode(input logic [2:0] m);
        do_reset(m, 1'b0);
        @(negedge clk);
        chk(run_en == 1'b1, "R1 other mode releases at once", run_en, 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!bm_rd && !pm_we && run_en, "R1 no traffic in skip mode", {run_en, pm_we, bm_rd}, 3'b100);
        end
    endtask

    task automatic byte_boot(input logic nar);
        int wcnt;
        bit prev_we;
        bit seen;
        seed = 8'($urandom);
        do_reset(3'b000, nar);
        wcnt = 0;
        prev_we = 1'b0;
        seen = 1'b0;
        for (int c = 0; c < 200 && !seen; c++) begin
            @(negedge clk);
            if (run_en) begin
                seen = 1'b1;
                chk(prev_we && wcnt == NW, "R6 release one cycle after last word", {prev_we, 8'(wcnt)}, {1'b1, 8'(NW)});
            end else begin
                if (bm_rd) begin
                    if (nar)
                        chk(bm_addr == BA_W'(rcount & 1), "R9 narrow address", bm_addr, rcount & 1);
                    else
                        chk(bm_addr == BA_W'(rcount), "R3 byte address", bm_addr, rcount);
                end
                if (pm_we) begin
                    chk(pm_addr == PA_W'(wcnt), "R5 word address order", pm_addr, wcnt);
                    chk(pm_wdata == word_fn(seed, wcnt), "R4 word packing", pm_wdata, word_fn(seed, wcnt));
                    wcnt++;
                end
                prev_we = pm_we;
                // R8/R10: disturb host port and mode pins during the load
                host_we   = 1'($urandom);
                host_addr = PA_W'($urandom % 4);
                host_data = 24'($urandom);
                if (c == 20) {mode_c, mode_b, mode_a} = 3'b101;
                if (c == 40) {mode_c, mode_b, mode_a} = 3'b011;
            end
        end
        chk(seen, "R2 run_en reached after byte load", seen, 1);
        host_we = 1'b1;
        host_addr = '0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!pm_we && run_en, "R8 no write after release", {run_en, pm_we}, 2'b10);
        end
        host_we = 1'b0;
        chk(rcount == 3 * NW, "R3 total reads", rcount, 3 * NW);
        chk(wcnt == NW, "R5 word count", wcnt, NW);
    endtask

    task automatic host_boot(input int n);
        logic [PA_W-1:0] a;
        logic [23:0]     d;
        do_reset(3'b101, 1'b0);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            a = PA_W'(1 + ($urandom % ((1 << PA_W) - 1)));
            d = 24'($urandom);
            host_we = 1'b1; host_addr = a; host_data = d;
            @(negedge clk);
            host_we = 1'b0;
            chk(pm_we && pm_addr == a && pm_wdata == d, "R7 host write forwarded", {pm_addr, pm_wdata}, {a, d});
            chk(!run_en, "R2 held during host load", run_en, 0);
            for (int g = 0; g < int'($urandom % 3); g++) begin
                @(negedge clk);
                chk(!pm_we && !run_en, "R7 idle between host writes", {run_en, pm_we}, 0);
            end
        end
        d = 24'($urandom);
        host_we = 1'b1; host_addr = '0; host_data = d;
        @(negedge clk);
        host_addr = PA_W'(5); host_data = 24'h5A5A5A;
        chk(pm_we && pm_addr == '0 && pm_wdata == d && !run_en, "R6 address-0 write before release",
            {run_en, pm_we, pm_wdata}, {2'b01, d});
        @(negedge clk);
        chk(run_en && !pm_we, "R8 write after address 0 dropped", {run_en, pm_we}, 2'b10);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(run_en && !pm_we, "R8 host write after release ignored", {run_en, pm_we}, 2'b10);
        end
        host_we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        skip_mode(3'b010);
        skip_mode(3'b001);
        skip_mode(3'b111);
        skip_mode(3'b100);
        byte_boot(1'b0);
        byte_boot(1'b1);
        host_boot(0);
        host_boot(1 + int'($urandom % 12));
        host_boot(20);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule